// File: doc/BRIEF.md
# Watchdog External Reset Pulse Shaper

This block turns a one-cycle expiry trigger from a watchdog counter into a timed reset pulse on an external pin. It counts ticks of a 1 MHz time base that is supplied as a one-cycle enable (`tick`) and keeps the pin asserted for a programmed number of those ticks. Both the active level and the drive style of the pin can be set. Push-pull drive keeps the output-enable high at all times. Open-drain drive raises the output-enable only while the pulse is asserted.

Software controls the block through one 32-bit configuration word. The low field holds the pulse duration minus one. The top byte acts as a key. Four exact byte values each change the polarity bit or the drive-mode bit. Any other value leaves both bits as they are. The read value always shows the width field and the two mode bits.

A two-state machine sequences the pulse. `PS_IDLE` waits for a trigger, and the transition *fire* (trigger seen) enters `PS_DRIVE` and loads the down-counter with the width field. `PS_DRIVE` counts down once per tick. The transition *expire* (a tick arrives with the counter at zero and no trigger present) returns to `PS_IDLE`. The transition *restart* (a trigger arrives during `PS_DRIVE`) stays in `PS_DRIVE` and reloads the counter.

Top module: `wdt_ext_pulse`

## Requirements
- R1: After reset, the configuration read value is 0x000000FF: width 0xFF, active-low (bit 31 = 0) and open-drain (bit 30 = 0). The pin sits at its idle level 1 with output-enable 0, and a trigger then gives a pulse of 256 ticks.
- R2: Every configuration write loads bits 19:0 of the written word into the width field. A read returns that field in bits 19:0. Bits 29:20 always read as 0, whatever value was written to them.
- R3: Writing a word whose bits 31:24 equal 0xA5 sets read bit 31, which selects active-high. Writing 0x5A in that byte clears bit 31, which selects active-low.
- R4: Writing a word whose bits 31:24 equal 0xA8 sets read bit 30, which selects push-pull. Writing 0x8A in that byte clears bit 30, which selects open-drain.
- R5: A write whose top byte is none of 0xA5, 0x5A, 0xA8 or 0x8A leaves read bits 31:30 unchanged.
- R6: A trigger sampled while idle asserts the pin from the next clock edge. The pin stays asserted for exactly width+1 cycles in which `tick` is high, and it deasserts at the edge that follows the last of those ticks.
- R7: The asserted pin level equals read bit 31, and the idle level is its inverse.
- R8: In push-pull mode the output-enable is always 1. In open-drain mode it is 1 only while the pulse is asserted.
- R9: A trigger sampled during a pulse reloads the count, so the pulse continues for width+1 further ticks counted from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle 1 MHz time-base enable |
| trigger | input | 1 | One-cycle watchdog expiry strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_rdata | output | 32 | Configuration read value |
| pin_out | output | 1 | Pin data level |
| pin_oe | output | 1 | Pin output-enable |

## Verification
The bench builds the block with its default parameters: a 20-bit width field and a reset width of 0xFF. With these values the bench can exercise the full-width field value 0xFFFFF through a read-back and the reset-default pulse of 256 ticks in full. Short programmed widths (0, 2, 3 and 4) run with a tick on every cycle and with a tick on every third cycle. This shows that pulse length is counted in ticks, not in clock cycles, and it gives a retrigger case whose restart can be told apart from the normal end of the pulse.

// File: rtl/pls_pkg.sv
package pls_pkg;

    localparam int unsigned CFG_W = 32;

    localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
    localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
    localparam logic [7:0] KEY_DRV_PUSH = 8'hA8;
    localparam logic [7:0] KEY_DRV_OPEN = 8'h8A;

    typedef enum logic [0:0] {
        PS_IDLE  = 1'b0,
        PS_DRIVE = 1'b1
    } pulse_state_e;

    typedef struct packed {
        logic active_high;
        logic push_pull;
    } pin_mode_t;

endpackage

// File: rtl/pls_cfg_reg.sv
module pls_cfg_reg
    import pls_pkg::*;
#(
    parameter int unsigned            WIDTH_BITS  = 20,
    parameter logic [WIDTH_BITS-1:0]  WIDTH_RESET = 'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_W-1:0]      cfg_wdata,
    output logic [WIDTH_BITS-1:0] width_q,
    output pin_mode_t             mode_q,
    output logic [CFG_W-1:0]      cfg_rdata
);

    localparam int unsigned POL_BIT = CFG_W - 1;
    localparam int unsigned DRV_BIT = CFG_W - 2;

    logic [7:0] key;
    pin_mode_t  mode_d;

    assign key = cfg_wdata[CFG_W-1 -: 8];

    always_comb begin
        mode_d = mode_q;
        if (cfg_we) begin
            unique case (key)
                KEY_POL_HIGH: mode_d.active_high = 1'b1;
                KEY_POL_LOW:  mode_d.active_high = 1'b0;
                KEY_DRV_PUSH: mode_d.push_pull   = 1'b1;
                KEY_DRV_OPEN: mode_d.push_pull   = 1'b0;
                default:      mode_d             = mode_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= WIDTH_RESET;
            mode_q  <= '{active_high: 1'b0, push_pull: 1'b0};
        end else begin
            mode_q <= mode_d;
            if (cfg_we) begin
                width_q <= cfg_wdata[WIDTH_BITS-1:0];
            end
        end
    end

    always_comb begin
        cfg_rdata                   = '0;
        cfg_rdata[WIDTH_BITS-1:0]   = width_q;
        cfg_rdata[POL_BIT]          = mode_q.active_high;
        cfg_rdata[DRV_BIT]          = mode_q.push_pull;
    end

endmodule

// File: rtl/pls_fsm.sv
module pls_fsm
    import pls_pkg::*;
#(
    parameter int unsigned WIDTH_BITS = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  trigger,
    input  logic [WIDTH_BITS-1:0] width,
    output logic                  asserted
);

    pulse_state_e          state_q;
    pulse_state_e          state_d;
    logic [WIDTH_BITS-1:0] cnt_q;
    logic                  last_tick;

    assign last_tick = tick && (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE:  if (trigger)                 state_d = PS_DRIVE;
            PS_DRIVE: if (!trigger && last_tick)   state_d = PS_IDLE;
            default:                               state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (trigger) begin
            cnt_q <= width;
        end else if (state_q == PS_DRIVE && tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        asserted = (state_q == PS_DRIVE);
    end

endmodule

// File: rtl/pls_pin_drv.sv
module pls_pin_drv
    import pls_pkg::*;
(
    input  logic      asserted,
    input  pin_mode_t mode,
    output logic      pin_out,
    output logic      pin_oe
);

    always_comb begin
        pin_out = asserted ? mode.active_high : ~mode.active_high;
        pin_oe  = mode.push_pull | asserted;
    end

endmodule

// File: rtl/wdt_ext_pulse.sv
module wdt_ext_pulse #(
    parameter int unsigned           WIDTH_BITS  = 20,
    parameter logic [WIDTH_BITS-1:0] WIDTH_RESET = 'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        trigger,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        pin_out,
    output logic        pin_oe
);

    import pls_pkg::*;

    logic [WIDTH_BITS-1:0] width_q;
    pin_mode_t             mode_q;
    logic                  asserted;

    pls_cfg_reg #(
        .WIDTH_BITS (WIDTH_BITS),
        .WIDTH_RESET(WIDTH_RESET)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .width_q  (width_q),
        .mode_q   (mode_q),
        .cfg_rdata(cfg_rdata)
    );

    pls_fsm #(
        .WIDTH_BITS(WIDTH_BITS)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .trigger (trigger),
        .width   (width_q),
        .asserted(asserted)
    );

    pls_pin_drv u_drv (
        .asserted(asserted),
        .mode    (mode_q),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

endmodule

// File: rtl/wdt_ext_pulse_chk.sv
module wdt_ext_pulse_chk
    import pls_pkg::*;
#(
    parameter int unsigned WIDTH_BITS = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        trigger,
    input logic        cfg_we,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        pin_out,
    input logic        pin_oe
);

    logic [7:0] key;
    logic       is_key;
    logic       on;

    assign key    = cfg_wdata[31:24];
    assign is_key = (key == KEY_POL_HIGH) || (key == KEY_POL_LOW) ||
                    (key == KEY_DRV_PUSH) || (key == KEY_DRV_OPEN);
    assign on     = (pin_out == cfg_rdata[31]);

    // R2
    width_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata[WIDTH_BITS-1:0] == $past(cfg_wdata[WIDTH_BITS-1:0]));

    // R3
    pol_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && key == KEY_POL_HIGH) |=> cfg_rdata[31]);

    // R4
    drv_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && key == KEY_DRV_OPEN) |=> !cfg_rdata[30]);

    // R5
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !is_key) |=> $stable(cfg_rdata[31:30]));

    // R8
    pp_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[30] |-> pin_oe);

    // R8
    od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdata[30] && !on) |-> !pin_oe);

    // R6
    fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> on);

    // R6
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!on && !trigger) |=> !on);

endmodule

bind wdt_ext_pulse wdt_ext_pulse_chk #(.WIDTH_BITS(WIDTH_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .trigger  (trigger),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
);

// File: tb/test_wdt_ext_pulse.sv
`timescale 1ns/1ps
module test_wdt_ext_pulse;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        trigger = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        pin_out;
    logic        pin_oe;

    int checks = 0;
    int fails = 0;
    int tick_period = 1;
    int tcnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdt_ext_pulse i_wdt_ext_pulse (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trigger(trigger),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // tick generator: updates 1 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            tcnt = (tcnt + 1 >= tick_period) ? 0 : tcnt + 1;
            tick = (tcnt == 0);
        end
    end

    // write value, expected read value
    localparam int NV = 8;
    localparam logic [63:0] VEC [NV] = '{
        {32'h00000010, 32'h00000010},   // R2 R5
        {32'hA5000020, 32'h80000020},   // R3
        {32'hA8000030, 32'hC0000030},   // R4
        {32'h12345678, 32'hC0045678},   // R5
        {32'h5A0FFFFF, 32'h400FFFFF},   // R3 R2
        {32'hA9000001, 32'h40000001},   // R5
        {32'h8A000003, 32'h00000003},   // R4
        {32'hFFF00002, 32'h00000002}    // R5 R2
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // fires a pulse; counts ticks seen while the pin is at level pol
    task automatic run_pulse(input logic pol, input int retrig_at,
                             output int nticks, output int oe_low);
        int idx;
        nticks = 0;
        oe_low = 0;
        @(negedge clk);
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        idx = 0;
        while (pin_out == pol && idx < 2000) begin
            if (tick) nticks++;
            if (!pin_oe) oe_low++;
            trigger = (idx == retrig_at);
            idx++;
            @(negedge clk);
        end
        trigger = 1'b0;
    endtask

    initial begin
        int nt;
        int ol;
        do_reset();

        // R1 reset state
        check("R1 reset rdata", cfg_rdata, 32'h000000FF);
        check("R1 reset pin_out", {31'd0, pin_out}, 32'd1);
        check("R1 reset pin_oe", {31'd0, pin_oe}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            cfg_write(VEC[i][63:32]);
            check($sformatf("R2/R3/R4/R5 vector %0d", i), cfg_rdata, VEC[i][31:0]);
        end

        // R6 R7 R8: push-pull, active-high, width 4, tick every cycle
        cfg_write(32'hA8000004);
        cfg_write(32'hA5000004);
        tick_period = 1;
        run_pulse(1'b1, -1, nt, ol);
        check("R6 width4 ticks", nt, 5);
        check("R8 pp oe during pulse", ol, 0);
        check("R7 idle level high-mode", {31'd0, pin_out}, 32'd0);
        check("R8 pp oe idle", {31'd0, pin_oe}, 32'd1);

        // R6 R7 R8: open-drain, active-low, width 2, tick every 3 cycles
        cfg_write(32'h5A000002);
        cfg_write(32'h8A000002);
        tick_period = 3;
        repeat (3) @(negedge clk);
        run_pulse(1'b0, -1, nt, ol);
        check("R6 width2 sparse ticks", nt, 3);
        check("R8 od oe during pulse", ol, 0);
        check("R7 idle level low-mode", {31'd0, pin_out}, 32'd1);
        check("R8 od oe idle", {31'd0, pin_oe}, 32'd0);

        // R6 width 0 gives one tick
        tick_period = 1;
        cfg_write(32'h00000000);
        run_pulse(1'b0, -1, nt, ol);
        check("R6 width0 ticks", nt, 1);

        // R9 retrigger after two asserted cycles, width 3
        cfg_write(32'h00000003);
        run_pulse(1'b0, 1, nt, ol);
        check("R9 retrigger ticks", nt, 6);
        check("R9 idle after retrigger", {31'd0, pin_out}, 32'd1);

        // R1 default width pulse after a fresh reset
        do_reset();
        check("R1 rdata after second reset", cfg_rdata, 32'h000000FF);
        run_pulse(1'b0, -1, nt, ol);
        check("R1 default pulse ticks", nt, 256);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule